// File: doc/BRIEF.md
# SPI Digital Potentiometer Bus Controller

This block is a memory-mapped slave on an AXI4-Lite bus. It holds one 8-bit wiper code for a digital potentiometer and drives that code out over a three-wire, write-only serial link. Any bus write to the register replaces the stored code and starts a serial frame. Software can read the register back at any time.

The serial side runs from its own external clock, which may be as fast as 25 MHz and has no phase relation to the bus clock. The serial clock pin is that external clock, gated so that it only toggles inside a frame.

A write hands its data to the serial side through a toggle request and a two-flop synchronizer. A toggle acknowledge returns the same way. A bus-side ready output reports whether the link has finished the work it was given. If writes arrive while a frame is on the wire, the bus side records them and sends the most recent value in one further frame once the current one completes.

Top module: `spi_pot_axil`

## Requirements
- R1: After reset the register reads 0, chip select is high, the serial clock output is low and ready is high.
- R2: A read of offset 0x0 returns the last value written there in bits 7:0, with bits 31:8 zero. Bits 31:8 of write data are discarded. Every write response and read response is OKAY (2'b00).
- R3: Each accepted write to offset 0x0 that starts a frame produces exactly 8 rising serial-clock edges while chip select is low. The data bits go out most significant bit first.
- R4: The serial data output changes only while the serial clock is low, so it is stable through each high phase.
- R5: Outside a frame the serial clock stays low and chip select stays high.
- R6: Ready falls once a write is accepted and stays low until the frame has ended. It rises only after chip select has returned high.
- R7: A write accepted while a frame is in flight updates the readable value at once and leaves the current frame intact. Exactly one further frame follows, carrying the latest value written.
- R8: Only offset 0x0 is decoded. A write to any other offset changes nothing and launches no frame. A read of any other offset returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| aclk | input | 1 | Bus clock |
| areset | input | 1 | Synchronous active-high reset, bus domain (synchronized internally for the serial side) |
| s_awaddr | input | 4 | Write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | 32 | Write data |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response, always OKAY |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | 4 | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response, always OKAY |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| ser_clk | input | 1 | External serial clock, up to 25 MHz |
| pot_ready | output | 1 | High when no frame is queued or in progress |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sclk | output | 1 | Serial clock, gated copy of ser_clk |
| spi_mosi | output | 1 | Serial data out |

## Verification
The bench sends values whose bit patterns expose ordering and length errors: all zeros, all ones, a lone top bit, a lone bottom bit and alternating bits. A reversed shift order, or a frame one bit too short or too long, shows up as a wrong captured byte or a wrong edge count. A watcher checks that the data line holds through each high phase of the serial clock and that no clock edge appears while chip select is high. Data launched on the wrong edge, or a clock gate that glitches, therefore gets caught. The overlap test writes twice during a live frame. A design that restarts the serializer would corrupt the first frame, one that queues every write would send three frames, and one that drops the pending flag would send only one. A separate check catches ready rising before chip select has gone back high, which is what a premature acknowledge would cause.

// File: rtl/spi_pot_pkg.sv
package spi_pot_pkg;
  localparam logic [1:0] RESP_OKAY = 2'b00;

  typedef enum logic [1:0] {
    SER_IDLE  = 2'd0,
    SER_SHIFT = 2'd1,
    SER_TAIL  = 2'd2
  } ser_state_t;
endpackage

// File: rtl/spi_pot_sync.sv
module spi_pot_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/spi_pot_bus.sv
module spi_pot_bus
  import spi_pot_pkg::*;
#(
  parameter int VAL_W  = 8,
  parameter int AXI_DW = 32,
  parameter int AXI_AW = 4,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [AXI_AW-1:0] awaddr,
  input  logic              awvalid,
  output logic              awready,
  input  logic [AXI_DW-1:0] wdata,
  input  logic              wvalid,
  output logic              wready,
  output logic [1:0]        bresp,
  output logic              bvalid,
  input  logic              bready,
  input  logic [AXI_AW-1:0] araddr,
  input  logic              arvalid,
  output logic              arready,
  output logic [AXI_DW-1:0] rdata,
  output logic [1:0]        rresp,
  output logic              rvalid,
  input  logic              rready,
  output logic              req_tgl_o,
  output logic [VAL_W-1:0]  snap_o,
  input  logic              done_tgl_i,
  output logic              ready_o
);
  localparam int PAD_W = AXI_DW - VAL_W;

  logic             wr_acc, ar_acc;
  logic [VAL_W-1:0] value_q, snap_q, value_nx;
  logic             busy_q, pending_q, req_tgl_q;
  logic             done_s, done_seen_q;
  logic             wr_hit, rd_hit, done_evt;
  logic             unused_hi;

  assign unused_hi = ^wdata[AXI_DW-1:VAL_W];

  spi_pot_sync #(.STAGES(SYNC_N)) u_done_sync (
    .clk(clk), .rst(rst), .d(done_tgl_i), .q(done_s)
  );

  assign wr_hit   = wr_acc && (awaddr == '0);
  assign rd_hit   = (araddr == '0);
  assign done_evt = (done_s != done_seen_q);
  assign value_nx = wr_hit ? wdata[VAL_W-1:0] : value_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_acc      <= 1'b0;
      ar_acc      <= 1'b0;
      bvalid      <= 1'b0;
      rvalid      <= 1'b0;
      rdata       <= '0;
      value_q     <= '0;
      snap_q      <= '0;
      busy_q      <= 1'b0;
      pending_q   <= 1'b0;
      req_tgl_q   <= 1'b0;
      done_seen_q <= 1'b0;
    end else begin
      wr_acc <= awvalid && wvalid && !bvalid && !wr_acc;
      ar_acc <= arvalid && !rvalid && !ar_acc;

      if (wr_acc)      bvalid <= 1'b1;
      else if (bready) bvalid <= 1'b0;

      if (ar_acc) begin
        rvalid <= 1'b1;
        rdata  <= rd_hit ? {{PAD_W{1'b0}}, value_q} : '0;
      end else if (rready) begin
        rvalid <= 1'b0;
      end

      value_q     <= value_nx;
      done_seen_q <= done_s;

      if (!busy_q) begin
        if (wr_hit) begin
          snap_q    <= value_nx;
          req_tgl_q <= ~req_tgl_q;
          busy_q    <= 1'b1;
        end
      end else if (done_evt) begin
        if (pending_q || wr_hit) begin
          snap_q    <= value_nx;
          req_tgl_q <= ~req_tgl_q;
          pending_q <= 1'b0;
        end else begin
          busy_q <= 1'b0;
        end
      end else if (wr_hit) begin
        pending_q <= 1'b1;
      end
    end
  end

  assign awready   = wr_acc;
  assign wready    = wr_acc;
  assign arready   = ar_acc;
  assign bresp     = RESP_OKAY;
  assign rresp     = RESP_OKAY;
  assign req_tgl_o = req_tgl_q;
  assign snap_o    = snap_q;
  assign ready_o   = ~busy_q;

  // R2: a response stays up until the master takes it
  p_bvalid_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (bvalid && !bready) |=> bvalid);
  p_rvalid_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (rvalid && !rready) |=> (rvalid && $stable(rdata)));
  // R6: busy starts only from an accepted write
  p_busy_rise_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_q) |-> $past(wr_acc));
  // R7: a queued write always keeps the link busy
  p_pending_busy_r7: assert property (@(posedge clk) disable iff (rst)
    pending_q |-> busy_q);
  // R7: the crossing data holds while its request is outstanding
  p_snap_stable_r7: assert property (@(posedge clk) disable iff (rst)
    (busy_q && $past(busy_q) && (req_tgl_q == $past(req_tgl_q))) |-> $stable(snap_q));
endmodule

// File: rtl/spi_pot_ser.sv
module spi_pot_ser
  import spi_pot_pkg::*;
#(
  parameter int VAL_W  = 8,
  parameter int SYNC_N = 2
) (
  input  logic             clk_n,
  input  logic             rst,
  input  logic             req_tgl_i,
  input  logic [VAL_W-1:0] data_i,
  output logic             cs_n_o,
  output logic             sclk_en_o,
  output logic             mosi_o,
  output logic             done_tgl_o
);
  localparam int CNT_W = $clog2(VAL_W);

  ser_state_t       state_q;
  logic [VAL_W-1:0] shreg_q;
  logic [CNT_W-1:0] cnt_q;
  logic             req_s, req_seen_q;

  spi_pot_sync #(.STAGES(SYNC_N)) u_req_sync (
    .clk(clk_n), .rst(rst), .d(req_tgl_i), .q(req_s)
  );

  always_ff @(posedge clk_n) begin
    if (rst) begin
      state_q    <= SER_IDLE;
      shreg_q    <= '0;
      cnt_q      <= '0;
      req_seen_q <= 1'b0;
      cs_n_o     <= 1'b1;
      sclk_en_o  <= 1'b0;
      mosi_o     <= 1'b0;
      done_tgl_o <= 1'b0;
    end else begin
      case (state_q)
        SER_IDLE: begin
          if (req_s != req_seen_q) begin
            req_seen_q <= req_s;
            mosi_o     <= data_i[VAL_W-1];
            shreg_q    <= data_i << 1;
            cnt_q      <= '0;
            cs_n_o     <= 1'b0;
            sclk_en_o  <= 1'b1;
            state_q    <= SER_SHIFT;
          end
        end
        SER_SHIFT: begin
          if (cnt_q == CNT_W'(VAL_W - 1)) begin
            cs_n_o    <= 1'b1;
            sclk_en_o <= 1'b0;
            mosi_o    <= 1'b0;
            state_q   <= SER_TAIL;
          end else begin
            mosi_o  <= shreg_q[VAL_W-1];
            shreg_q <= shreg_q << 1;
            cnt_q   <= cnt_q + 1'b1;
          end
        end
        default: begin
          done_tgl_o <= ~done_tgl_o;
          state_q    <= SER_IDLE;
        end
      endcase
    end
  end

  // R3: chip select releases only after the full bit count
  p_frame_len_r3: assert property (@(posedge clk_n) disable iff (rst)
    $rose(cs_n_o) |-> ($past(cnt_q) == CNT_W'(VAL_W - 1)));
  // R6: the acknowledge toggles only with chip select already high
  p_done_after_cs_r6: assert property (@(posedge clk_n) disable iff (rst)
    !$stable(done_tgl_o) |-> (cs_n_o && $past(cs_n_o)));
  // R5: no new frame begins while the link is not idle
  p_start_idle_r5: assert property (@(posedge clk_n) disable iff (rst)
    $fell(cs_n_o) |-> $past(state_q == SER_IDLE));
endmodule

// File: rtl/spi_pot_axil.sv
module spi_pot_axil #(
  parameter int VAL_W  = 8,
  parameter int AXI_DW = 32,
  parameter int AXI_AW = 4,
  parameter int SYNC_N = 2
) (
  input  logic              aclk,
  input  logic              areset,
  input  logic [AXI_AW-1:0] s_awaddr,
  input  logic              s_awvalid,
  output logic              s_awready,
  input  logic [AXI_DW-1:0] s_wdata,
  input  logic              s_wvalid,
  output logic              s_wready,
  output logic [1:0]        s_bresp,
  output logic              s_bvalid,
  input  logic              s_bready,
  input  logic [AXI_AW-1:0] s_araddr,
  input  logic              s_arvalid,
  output logic              s_arready,
  output logic [AXI_DW-1:0] s_rdata,
  output logic [1:0]        s_rresp,
  output logic              s_rvalid,
  input  logic              s_rready,
  input  logic              ser_clk,
  output logic              pot_ready,
  output logic              spi_cs_n,
  output logic              spi_sclk,
  output logic              spi_mosi
);
  logic             ser_clk_n, ser_rst;
  logic             req_tgl, done_tgl, sclk_en;
  logic [VAL_W-1:0] snap;

  assign ser_clk_n = ~ser_clk;

  spi_pot_sync #(.STAGES(SYNC_N)) u_rst_sync (
    .clk(ser_clk_n), .rst(1'b0), .d(areset), .q(ser_rst)
  );

  spi_pot_bus #(
    .VAL_W(VAL_W), .AXI_DW(AXI_DW), .AXI_AW(AXI_AW), .SYNC_N(SYNC_N)
  ) u_bus (
    .clk(aclk), .rst(areset),
    .awaddr(s_awaddr), .awvalid(s_awvalid), .awready(s_awready),
    .wdata(s_wdata), .wvalid(s_wvalid), .wready(s_wready),
    .bresp(s_bresp), .bvalid(s_bvalid), .bready(s_bready),
    .araddr(s_araddr), .arvalid(s_arvalid), .arready(s_arready),
    .rdata(s_rdata), .rresp(s_rresp), .rvalid(s_rvalid), .rready(s_rready),
    .req_tgl_o(req_tgl), .snap_o(snap), .done_tgl_i(done_tgl),
    .ready_o(pot_ready)
  );

  spi_pot_ser #(.VAL_W(VAL_W), .SYNC_N(SYNC_N)) u_ser (
    .clk_n(ser_clk_n), .rst(ser_rst),
    .req_tgl_i(req_tgl), .data_i(snap),
    .cs_n_o(spi_cs_n), .sclk_en_o(sclk_en), .mosi_o(spi_mosi),
    .done_tgl_o(done_tgl)
  );

  // The enable changes on the falling edge, while ser_clk is low, so the gated clock cannot glitch.
  assign spi_sclk = ser_clk & sclk_en;
endmodule

// File: tb/tb_spi_pot_axil.sv
`timescale 1ns/1ps
module tb_spi_pot_axil;
  localparam real BUS_HALF = 2.0;
  localparam real SER_HALF = 20.0;

  logic        aclk = 0, areset = 1, ser_clk = 0;
  logic [3:0]  s_awaddr = 0, s_araddr = 0;
  logic        s_awvalid = 0, s_wvalid = 0, s_bready = 0, s_arvalid = 0, s_rready = 0;
  logic [31:0] s_wdata = 0;
  logic        s_awready, s_wready, s_bvalid, s_arready, s_rvalid;
  logic [1:0]  s_bresp, s_rresp;
  logic [31:0] s_rdata;
  logic        pot_ready, spi_cs_n, spi_sclk, spi_mosi;

  int checks = 0, fails = 0;
  int nframes = 0, stray = 0, mosi_bad = 0, ready_early = 0, bitcnt = 0;
  logic [7:0] shin;
  logic [7:0] fval [0:63];
  int         fbits[0:63];
  logic       mon_on = 0;

  always #(BUS_HALF) aclk = ~aclk;
  initial begin #7; forever #(SER_HALF) ser_clk = ~ser_clk; end

  spi_pot_axil dut (
    .aclk(aclk), .areset(areset),
    .s_awaddr(s_awaddr), .s_awvalid(s_awvalid), .s_awready(s_awready),
    .s_wdata(s_wdata), .s_wvalid(s_wvalid), .s_wready(s_wready),
    .s_bresp(s_bresp), .s_bvalid(s_bvalid), .s_bready(s_bready),
    .s_araddr(s_araddr), .s_arvalid(s_arvalid), .s_arready(s_arready),
    .s_rdata(s_rdata), .s_rresp(s_rresp), .s_rvalid(s_rvalid), .s_rready(s_rready),
    .ser_clk(ser_clk), .pot_ready(pot_ready),
    .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi)
  );

  // serial monitor: capture frames, stray edges, data stability
  always @(posedge spi_sclk) begin
    if (mon_on) begin
      if (spi_cs_n) stray++;
      else begin shin = {shin[6:0], spi_mosi}; bitcnt++; end
    end
  end
  always @(posedge spi_sclk) begin
    logic v;
    v = spi_mosi;
    #(SER_HALF / 2);
    if (mon_on && spi_mosi !== v) mosi_bad++;
  end
  always @(negedge spi_cs_n) begin bitcnt = 0; shin = 0; end
  always @(posedge spi_cs_n) begin
    if (mon_on) begin
      if (pot_ready === 1'b1) ready_early++;
      if (nframes < 64) begin fval[nframes] = shin; fbits[nframes] = bitcnt; end
      nframes++;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] addr, input logic [31:0] data);
    @(negedge aclk);
    s_awaddr = addr; s_wdata = data; s_awvalid = 1; s_wvalid = 1;
    do @(negedge aclk); while (!s_awready);
    @(posedge aclk); #0.5;
    s_awvalid = 0; s_wvalid = 0; s_bready = 1;
    do @(negedge aclk); while (!s_bvalid);
    chk(s_bresp == 2'b00, "R2 bresp", 32'(s_bresp), 0);
    @(posedge aclk); #0.5;
    s_bready = 0;
  endtask

  task automatic bus_read(input logic [3:0] addr, output logic [31:0] data);
    @(negedge aclk);
    s_araddr = addr; s_arvalid = 1;
    do @(negedge aclk); while (!s_arready);
    @(posedge aclk); #0.5;
    s_arvalid = 0; s_rready = 1;
    do @(negedge aclk); while (!s_rvalid);
    data = s_rdata;
    chk(s_rresp == 2'b00, "R2 rresp", 32'(s_rresp), 0);
    @(posedge aclk); #0.5;
    s_rready = 0;
  endtask

  task automatic wait_idle();
    repeat (4) @(negedge aclk);
    while (!pot_ready) @(negedge aclk);
    repeat (40) @(negedge aclk);
  endtask

  task automatic t_reset();
    logic [31:0] rd;
    chk(spi_cs_n === 1'b1, "R1 cs_n", 32'(spi_cs_n), 1);
    chk(spi_sclk === 1'b0, "R1 sclk", 32'(spi_sclk), 0);
    chk(pot_ready === 1'b1, "R1 ready", 32'(pot_ready), 1);
    bus_read(4'h0, rd);
    chk(rd == 0, "R1 value", rd, 0);
  endtask

  task automatic t_frame(input logic [31:0] wv);
    logic [31:0] rd;
    int base;
    base = nframes;
    bus_write(4'h0, wv);
    @(negedge aclk);
    chk(pot_ready === 1'b0, "R6 ready low after write", 32'(pot_ready), 0);
    wait_idle();
    chk(nframes == base + 1, "R3 frame count", nframes - base, 1);
    chk(fbits[base] == 8, "R3 bit count", fbits[base], 8);
    chk(fval[base] == wv[7:0], "R3 msb-first data", 32'(fval[base]), 32'(wv[7:0]));
    bus_read(4'h0, rd);
    chk(rd == {24'h0, wv[7:0]}, "R2 readback", rd, {24'h0, wv[7:0]});
  endtask

  task automatic t_overlap();
    logic [31:0] rd;
    int base;
    base = nframes;
    bus_write(4'h0, 32'h11);
    while (spi_cs_n) @(negedge aclk);
    bus_write(4'h0, 32'h22);
    bus_write(4'h0, 32'h33);
    bus_read(4'h0, rd);
    chk(rd == 32'h33, "R7 readback during frame", rd, 32'h33);
    wait_idle();
    chk(nframes == base + 2, "R7 frame count", nframes - base, 2);
    chk(fval[base] == 8'h11, "R7 first frame intact", 32'(fval[base]), 32'h11);
    chk(fbits[base] == 8, "R7 first frame length", fbits[base], 8);
    chk(fval[base+1] == 8'h33, "R7 latest value sent", 32'(fval[base+1]), 32'h33);
  endtask

  task automatic t_decode();
    logic [31:0] rd;
    int base;
    base = nframes;
    bus_write(4'h4, 32'h77);
    repeat (3) @(negedge aclk);
    chk(pot_ready === 1'b1, "R8 no busy on other offset", 32'(pot_ready), 1);
    wait_idle();
    chk(nframes == base, "R8 no frame on other offset", nframes - base, 0);
    bus_read(4'h0, rd);
    chk(rd == 32'h33, "R8 register untouched", rd, 32'h33);
    bus_read(4'hC, rd);
    chk(rd == 0, "R8 other offset reads zero", rd, 0);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 2 * BUS_HALF);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (60) @(posedge aclk);
    #0.5 areset = 0;
    repeat (40) @(negedge aclk);
    mon_on = 1;
    t_reset();
    t_frame(32'h0000_00A5);
    t_frame(32'h0000_0000);
    t_frame(32'h0000_00FF);
    t_frame(32'h0000_0080);
    t_frame(32'h0000_0001);
    t_frame(32'hDEAD_BE3C);
    t_overlap();
    t_decode();
    chk(stray == 0, "R5 no clock outside frame", stray, 0);
    chk(spi_sclk === 1'b0 && spi_cs_n === 1'b1, "R5 idle levels", {30'h0, spi_sclk, spi_cs_n}, 1);
    chk(mosi_bad == 0, "R4 data stable in high phase", mosi_bad, 0);
    chk(ready_early == 0, "R6 ready after cs release", ready_early, 0);
    finish_run();
  end
endmodule